// File: doc/BRIEF.md
# Variable-Length Graphics Command Parser

This block sits between a byte-wide host channel (typically the read side of an input FIFO) and the drawing side of a graphics controller. It frames the incoming byte stream into commands. The value range of the first byte, the opcode, fixes how many bytes the command has. Short commands are handed downstream as a 16-bit control word. Longer commands load 16-bit, 24-bit or 32-bit signed integers straight into a bank of 64 parameter registers. One control word copies parameter registers 0 and 1 into the two 16-bit scaler controls, whose values express a scale of N:65536.

The parser is built around a three-state machine. ST_WAIT_OP waits for an opcode. When a byte is accepted, it records the opcode class, the target register and the number of payload bytes still due, and moves to ST_GATHER. ST_GATHER shifts in payload bytes. On the last byte it issues a control word or a register write and returns to ST_WAIT_OP. For a 24-bit or 32-bit payload it issues the low write and moves on to ST_FLUSH_HI. ST_FLUSH_HI issues the upper-register write as soon as the consumer is ready, then returns to ST_WAIT_OP. A byte is taken only while the consumer can accept a strobe, so no strobe is ever dropped.

Top module: `gcp_cmd_parser`

## Requirements
- R1: After reset the parser is in the opcode-wait state with in_ready high (given down_ready high), no strobe is active, scale_x and scale_y are zero, and all 64 parameter registers read as zero.
- R2: An opcode in 0x00..0x7F is followed by one parameter byte. The cycle after that byte is accepted, ctrl_valid is high for one cycle and ctrl_word = {opcode, parameter}.
- R3: An opcode in 0x80..0xBF is followed by two payload bytes, most significant first. The cycle after the last byte, reg_we pulses once with reg_addr = opcode[5:0] and reg_wdata = the 16-bit payload.
- R4: An opcode in 0xC0..0xDF is followed by three payload bytes, most significant first. With k = opcode[4:0], register 2k takes payload[15:0] in the cycle after the last byte. In the next cycle, register 2k+1 takes payload[23:16] sign-extended to 16 bits.
- R5: An opcode in 0xE0..0xFF is followed by four payload bytes, most significant first. With k = opcode[4:0], register 2k takes payload[15:0] in the cycle after the last byte. In the next cycle, register 2k+1 takes payload[31:16].
- R6: The control word 0x0903 raises scale_valid together with ctrl_valid and loads scale_x from register 0 and scale_y from register 1, using the register contents present when the command completes.
- R7: Every other control word, 0x0900 included, leaves scale_valid low and scale_x and scale_y unchanged.
- R8: While down_ready is low, in_ready is low, no byte is taken and no strobe is raised in the following cycle. A pending upper-register write waits until down_ready returns.
- R9: ctrl_valid and reg_we are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host byte present |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Byte taken at this edge when in_valid is high |
| down_ready | input | 1 | Downstream consumer can take a strobe |
| ctrl_valid | output | 1 | Control word strobe |
| ctrl_word | output | 16 | Opcode and parameter of a short command |
| reg_we | output | 1 | Parameter register write strobe |
| reg_addr | output | 6 | Parameter register index |
| reg_wdata | output | 16 | Parameter register write data |
| scale_valid | output | 1 | Scaler controls updated |
| scale_x | output | 16 | Horizontal scale control |
| scale_y | output | 16 | Vertical scale control |

## Verification
The hardest case to reach is the ST_FLUSH_HI wait. The consumer has to withdraw down_ready in the single cycle after the last byte of a 32-bit command, after the low write has gone out and before the upper write. The bench drives that final byte by hand and lowers down_ready at the next falling edge. It then checks that exactly one write stays logged over several cycles, and that the upper write appears at register 2k+1 once down_ready returns. Register 0 and register 1 are only visible through the scaler latch. Reset clearing is therefore shown by issuing 0x0903 directly after reset.

// File: rtl/gcp_pkg.sv
package gcp_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_OP,
        ST_GATHER,
        ST_FLUSH_HI
    } state_t;

    typedef enum logic [1:0] {
        K_CTRL,
        K_SET16,
        K_SET24,
        K_SET32
    } kind_t;

endpackage

// File: rtl/gcp_op_decode.sv
module gcp_op_decode
    import gcp_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [7:0]    op,
    output kind_t         kind,
    output logic [2:0]    nbytes,
    output logic [AW-1:0] base
);
    always_comb begin
        kind   = K_CTRL;
        nbytes = 3'd1;
        unique case (op[7:6])
            2'b00, 2'b01: begin
                kind   = K_CTRL;
                nbytes = 3'd1;
            end
            2'b10: begin
                kind   = K_SET16;
                nbytes = 3'd2;
            end
            2'b11: begin
                kind   = op[5] ? K_SET32 : K_SET24;
                nbytes = op[5] ? 3'd4 : 3'd3;
            end
            default: ;
        endcase
        if (kind == K_SET16) base = op[AW-1:0];
        else                 base = {op[AW-2:0], 1'b0};
    end
endmodule

// File: rtl/gcp_payload_sr.sv
module gcp_payload_sr #(
    parameter int BW = 8,
    parameter int NB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic [BW-1:0]    din,
    output logic [NB*BW-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (shift) q <= {q[(NB-1)*BW-1:0], din};
    end
endmodule

// File: rtl/gcp_param_bank.sv
module gcp_param_bank #(
    parameter int N     = 64,
    parameter int W     = 16,
    parameter int IDX_A = 0,
    parameter int IDX_B = 1,
    localparam int AW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rd_a = mem[IDX_A];
    assign rd_b = mem[IDX_B];
endmodule

// File: rtl/gcp_cmd_parser.sv
module gcp_cmd_parser
    import gcp_pkg::*;
#(
    parameter int NREGS           = 64,
    parameter int W               = 16,
    parameter logic [15:0] LATCH_WORD = 16'h0903,
    localparam int AW             = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    input  logic          down_ready,
    output logic          ctrl_valid,
    output logic [15:0]   ctrl_word,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [W-1:0]  reg_wdata,
    output logic          scale_valid,
    output logic [W-1:0]  scale_x,
    output logic [W-1:0]  scale_y
);
    state_t        state_q, state_d;
    kind_t         kind_q, dec_kind;
    logic [2:0]    rem_q, dec_nb;
    logic [AW-1:0] base_q, dec_base;
    logic [7:0]    op_q;
    logic [W-1:0]  hi_q;
    logic [23:0]   sr;
    logic [W-1:0]  bank_x, bank_y;
    logic          accept, last_byte;

    gcp_op_decode #(.AW(AW)) u_dec (
        .op(in_data), .kind(dec_kind), .nbytes(dec_nb), .base(dec_base)
    );

    gcp_payload_sr #(.BW(8), .NB(3)) u_sr (
        .clk(clk), .rst_n(rst_n),
        .shift(accept && state_q == ST_GATHER),
        .din(in_data), .q(sr)
    );

    gcp_param_bank #(.N(NREGS), .W(W), .IDX_A(0), .IDX_B(1)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rd_a(bank_x), .rd_b(bank_y)
    );

    assign in_ready  = down_ready && (state_q != ST_FLUSH_HI);
    assign accept    = in_valid && in_ready;
    assign last_byte = accept && (state_q == ST_GATHER) && (rem_q == 3'd1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_OP:  if (accept) state_d = ST_GATHER;
            ST_GATHER:   if (last_byte)
                             state_d = (kind_q == K_SET24 || kind_q == K_SET32)
                                       ? ST_FLUSH_HI : ST_WAIT_OP;
            ST_FLUSH_HI: if (down_ready) state_d = ST_WAIT_OP;
            default:     state_d = ST_WAIT_OP;
        endcase
    end

    // State register and command context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_OP;
            kind_q  <= K_CTRL;
            rem_q   <= '0;
            base_q  <= '0;
            op_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept && state_q == ST_WAIT_OP) begin
                kind_q <= dec_kind;
                rem_q  <= dec_nb;
                base_q <= dec_base;
                op_q   <= in_data;
            end else if (accept && state_q == ST_GATHER) begin
                rem_q <= rem_q - 3'd1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_valid  <= 1'b0;
            ctrl_word   <= '0;
            reg_we      <= 1'b0;
            reg_addr    <= '0;
            reg_wdata   <= '0;
            scale_valid <= 1'b0;
            scale_x     <= '0;
            scale_y     <= '0;
            hi_q        <= '0;
        end else begin
            ctrl_valid  <= 1'b0;
            reg_we      <= 1'b0;
            scale_valid <= 1'b0;
            if (last_byte) begin
                unique case (kind_q)
                    K_CTRL: begin
                        ctrl_valid <= 1'b1;
                        ctrl_word  <= {op_q, in_data};
                        if ({op_q, in_data} == LATCH_WORD) begin
                            scale_valid <= 1'b1;
                            scale_x     <= bank_x;
                            scale_y     <= bank_y;
                        end
                    end
                    K_SET16, K_SET24, K_SET32: begin
                        reg_we    <= 1'b1;
                        reg_addr  <= base_q;
                        reg_wdata <= {sr[7:0], in_data};
                        if (kind_q == K_SET24) hi_q <= {{8{sr[15]}}, sr[15:8]};
                        else                   hi_q <= sr[23:8];
                    end
                    default: ;
                endcase
            end else if (state_q == ST_FLUSH_HI && down_ready) begin
                reg_we    <= 1'b1;
                reg_addr  <= base_q + AW'(1);
                reg_wdata <= hi_q;
            end
        end
    end
endmodule

// File: rtl/gcp_parser_chk.sv
module gcp_parser_chk #(
    parameter int AW = 6,
    parameter int W  = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          down_ready,
    input logic          ctrl_valid,
    input logic [15:0]   ctrl_word,
    input logic          reg_we,
    input logic          scale_valid,
    input logic [W-1:0]  scale_x,
    input logic [W-1:0]  scale_y
);
    p_no_strobe_after_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!down_ready) |=> (!ctrl_valid && !reg_we));

    p_ready_needs_consumer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> down_ready);

    p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_valid, reg_we}));

    p_short_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |-> (ctrl_word[15] == 1'b0));

    p_latch_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scale_valid |-> (ctrl_valid && ctrl_word == 16'h0903));

    p_scale_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!scale_valid && $past(rst_n)) |-> ($stable(scale_x) && $stable(scale_y)));
endmodule

bind gcp_cmd_parser gcp_parser_chk #(.AW(AW), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .down_ready(down_ready),
    .ctrl_valid(ctrl_valid), .ctrl_word(ctrl_word), .reg_we(reg_we),
    .scale_valid(scale_valid), .scale_x(scale_x), .scale_y(scale_y)
);

// File: tb/sim_gcp_cmd_parser.sv
`timescale 1ns/1ps
module sim_gcp_cmd_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        down_ready = 1'b1;
    logic        ctrl_valid;
    logic [15:0] ctrl_word;
    logic        reg_we;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        scale_valid;
    logic [15:0] scale_x, scale_y;

    always #5 clk = ~clk;

    gcp_cmd_parser u0 (.*);

    int checks = 0, failures = 0, cyc = 0;
    int n_ctrl = 0, n_we = 0, n_scale = 0, n_both = 0;
    logic [15:0] last_ctrl;
    logic [5:0]  we_addr [4];
    logic [15:0] we_data [4];
    int          we_cyc  [4];
    logic [15:0] model [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (ctrl_valid && reg_we) n_both++;
        if (ctrl_valid) begin n_ctrl++; last_ctrl = ctrl_word; end
        if (scale_valid) n_scale++;
        if (reg_we) begin
            if (n_we < 4) begin
                we_addr[n_we] = reg_addr; we_data[n_we] = reg_wdata; we_cyc[n_we] = cyc;
            end
            n_we++;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_ctrl = 0; n_we = 0; n_scale = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 64; i++) model[i] = '0;
        @(negedge clk);
        clear_logs();
    endtask

    task automatic latch_check(input string req);
        clear_logs();
        send_byte(8'h09); send_byte(8'h03); settle();
        check(n_scale == 1 && n_ctrl == 1, req, n_scale, 1);
        check(scale_x == model[0] && scale_y == model[1], req,
              {scale_x, scale_y}, {model[0], model[1]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check(in_ready && !ctrl_valid && !reg_we && !scale_valid, "R1 idle outputs",
              {in_ready, ctrl_valid, reg_we, scale_valid}, 4'b1000);
        check(scale_x == 0 && scale_y == 0, "R1 scale zero", {scale_x, scale_y}, 0);
        latch_check("R1 R6 registers cleared");

        // R2 and R7: all short opcodes
        for (int op = 0; op < 128; op++) begin
            logic [7:0] p;
            logic [15:0] sx, sy;
            p = 8'((op * 37 + 5) & 255);
            sx = scale_x; sy = scale_y;
            clear_logs();
            send_byte(8'(op)); send_byte(p); settle();
            check(n_ctrl == 1 && n_we == 0 && last_ctrl == {8'(op), p}, "R2 control word",
                  last_ctrl, {8'(op), p});
            check(n_scale == 0 && scale_x == sx && scale_y == sy, "R7 no latch", n_scale, 0);
        end

        // R3: 16-bit loads to every register
        for (int i = 0; i < 64; i++) begin
            logic [15:0] v;
            v = 16'((i * 1237 + 32769) & 16'hFFFF);
            clear_logs();
            send_byte(8'(128 + i)); send_byte(v[15:8]); send_byte(v[7:0]); settle();
            model[i] = v;
            check(n_we == 1 && we_addr[0] == 6'(i) && we_data[0] == v, "R3 16-bit write",
                  {we_addr[0], we_data[0]}, {6'(i), v});
        end
        latch_check("R6 after R3 loads");

        // R4: 24-bit loads to every pair
        for (int k = 0; k < 32; k++) begin
            logic [23:0] v;
            logic [15:0] hi;
            v = 24'((k * 107461 + ((k & 1) << 23)) & 24'hFFFFFF);
            hi = {{8{v[23]}}, v[23:16]};
            clear_logs();
            send_byte(8'(192 + k)); send_byte(v[23:16]); send_byte(v[15:8]); send_byte(v[7:0]);
            settle();
            model[2*k] = v[15:0]; model[2*k+1] = hi;
            check(n_we == 2 && we_addr[0] == 6'(2*k) && we_data[0] == v[15:0], "R4 low write",
                  {we_addr[0], we_data[0]}, {6'(2*k), v[15:0]});
            check(we_addr[1] == 6'(2*k+1) && we_data[1] == hi && we_cyc[1] == we_cyc[0] + 1,
                  "R4 sign-extended high write", {we_addr[1], we_data[1]}, {6'(2*k+1), hi});
        end
        latch_check("R6 after R4 loads");

        // R5: 32-bit loads to every pair
        for (int k = 0; k < 32; k++) begin
            logic [31:0] v;
            v = 32'(k) * 32'h9E3779B1 + 32'h01234567;
            clear_logs();
            send_byte(8'(224 + k)); send_byte(v[31:24]); send_byte(v[23:16]);
            send_byte(v[15:8]); send_byte(v[7:0]); settle();
            model[2*k] = v[15:0]; model[2*k+1] = v[31:16];
            check(n_we == 2 && we_addr[0] == 6'(2*k) && we_data[0] == v[15:0], "R5 low write",
                  {we_addr[0], we_data[0]}, {6'(2*k), v[15:0]});
            check(we_addr[1] == 6'(2*k+1) && we_data[1] == v[31:16] && we_cyc[1] == we_cyc[0] + 1,
                  "R5 high write", {we_addr[1], we_data[1]}, {6'(2*k+1), v[31:16]});
        end

        // R6 / R7: latch word versus 0x0900
        send_byte(8'h80); send_byte(8'h12); send_byte(8'h34); model[0] = 16'h1234;
        send_byte(8'h81); send_byte(8'hFE); send_byte(8'hDC); model[1] = 16'hFEDC;
        settle();
        latch_check("R6 latch 0x0903");
        send_byte(8'h80); send_byte(8'h55); send_byte(8'h55); settle();
        clear_logs();
        send_byte(8'h09); send_byte(8'h00); settle();
        check(n_ctrl == 1 && n_scale == 0 && scale_x == 16'h1234, "R7 0x0900 ignored",
              scale_x, 16'h1234);
        model[0] = 16'h5555;
        latch_check("R6 latch sees new value");

        // R8: stall before an opcode
        clear_logs();
        @(negedge clk); down_ready = 1'b0; in_valid = 1'b1; in_data = 8'h85;
        repeat (4) begin
            @(negedge clk);
            check(!in_ready, "R8 ready low while stalled", in_ready, 0);
        end
        down_ready = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        check(n_ctrl == 0 && n_we == 0, "R8 no strobe while stalled", n_we, 0);
        send_byte(8'h12); send_byte(8'h34); settle();
        check(n_we == 1 && we_addr[0] == 6'd5 && we_data[0] == 16'h1234, "R8 opcode taken after stall",
              {we_addr[0], we_data[0]}, {6'd5, 16'h1234});

        // R8: stall between low and high write of a 32-bit load
        clear_logs();
        send_byte(8'hE1); send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
        @(negedge clk); in_valid = 1'b1; in_data = 8'hD4;
        @(negedge clk); in_valid = 1'b0; down_ready = 1'b0;
        repeat (4) @(negedge clk);
        check(n_we == 1 && we_addr[0] == 6'd2 && we_data[0] == 16'hC3D4, "R8 low write before stall",
              {n_we, we_data[0]}, {1, 16'hC3D4});
        check(!in_ready, "R8 ready low during pending write", in_ready, 0);
        down_ready = 1'b1;
        settle();
        check(n_we == 2 && we_addr[1] == 6'd3 && we_data[1] == 16'hA1B2, "R8 high write after stall",
              {we_addr[1], we_data[1]}, {6'd3, 16'hA1B2});

        // R1: reset clears the bank again
        do_reset();
        latch_check("R1 reset clears registers");

        // R9
        check(n_both == 0, "R9 strobes exclusive", n_both, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule